// File: doc/BRIEF.md
# Multi-Target SPI Bus Master

This block is a synchronous serial bus master that runs full-duplex byte exchanges with one of several attached targets. Each target has its own active-low select line. A command gives the target index, the number of bytes, the clock polarity and phase, the level of a data/command line for display-style targets, and a divider for the serial clock. The master then streams bytes from a transmit valid/ready input onto MOSI and hands every byte shifted in from MISO to a receive valid/ready output.

No received byte is ever dropped, even when the transmitted byte was only filler. If the receive consumer is not ready, the serial clock freezes with the select held low until the byte has been taken. If the transmit producer has no byte ready, the master also waits between bytes with the clock at its idle level.

Top module: `spi_xfer_master`

## Requirements
- R1: While every select line is high, `sck` equals the clock polarity of the most recently accepted command (0 after reset). `sck` toggles only while a select is low.
- R2: Bytes go out most significant bit first. With `cmd_cpha`=0, MISO is sampled and MOSI is checked on the first `sck` edge of each bit, and the next bit is launched on the second edge. With `cmd_cpha`=1, the bit is launched on the first edge and sampled on the second.
- R3: During a command, only `cs_n[cmd_slave]` is low, and it stays low from the first byte until after the last one. At most one select is ever low.
- R4: A command with `cmd_len`=L transfers L+1 bytes, which is 16*(L+1) `sck` edges for 8-bit bytes. Every transfer yields one byte on `rx_data`, delivered in bus order.
- R5: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high, `rx_data` stays stable and `sck` does not toggle.
- R6: `dc` takes the value of `cmd_dc` before the select falls and does not change while the select is low.
- R7: Within a byte, consecutive `sck` edges are exactly H system cycles apart, where H is `cmd_div`, or 1 when `cmd_div` is 0.
- R8: At least H cycles separate the select falling from the first `sck` edge. At least H cycles also separate the last `sck` edge from the select rising. Between bytes, the gap between edges is at least H.
- R9: While the master waits for a transmit byte (`tx_ready` high, `tx_valid` low), `sck` holds the idle level.
- R10: `cmd_ready` is high only when no select is low, and it drops in the cycle after a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_slave | input | SEL_W | Target index |
| cmd_len | input | LEN_W | Byte count minus one |
| cmd_cpol | input | 1 | Idle level of sck |
| cmd_cpha | input | 1 | 0: sample on first edge, 1: sample on second edge |
| cmd_dc | input | 1 | Level for the data/command line |
| cmd_div | input | DIV_W | Half period of sck in system cycles (0 treated as 1) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte taken when high with tx_valid |
| tx_data | input | BYTE_W | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | BYTE_W | Received byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to target |
| miso | input | 1 | Serial data from target |
| cs_n | output | N_SLV | Active-low per-target selects |
| dc | output | 1 | Data/command line |

## Verification
Two events can fall due on the same system cycle: a completed receive byte waiting on a consumer that is not ready, and the half-period timer that would otherwise produce the next `sck` edge. The bench holds `rx_ready` low for several cycles after `rx_valid` rises, in every mode and at several dividers. At each clock a behavioural target model checks that no `sck` edge appears while a byte is pending and that the pending byte does not change. Starving the transmit stream in the same runs also checks that the frozen clock and the idle-level wait never corrupt the shifted data or the edge spacing.

// File: rtl/spx_pkg.sv
package spx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_FETCH,
      ST_RUN,
      ST_RXOUT,
      ST_TAIL
   } spx_state_e;

   typedef struct packed {
      logic cpol;
      logic cpha;
      logic dc;
   } spx_mode_t;
endpackage

// File: rtl/spx_tick.sv
module spx_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= half - 1'b1;
      end else if (run) begin
         cnt_q <= (cnt_q == '0) ? half - 1'b1 : cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/spx_shift.sv
module spx_shift #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              launch,
   input  logic              sample,
   input  logic              miso,
   output logic              mosi,
   output logic [BYTE_W-1:0] rx_byte
);
   logic [BYTE_W-1:0] txs_q;
   logic [BYTE_W-1:0] rxs_q;

   assign mosi    = txs_q[BYTE_W-1];
   assign rx_byte = rxs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txs_q <= '0;
         rxs_q <= '0;
      end else begin
         if (load) begin
            txs_q <= load_val;
         end else if (launch) begin
            txs_q <= {txs_q[BYTE_W-2:0], 1'b0};
         end
         if (sample) begin
            rxs_q <= {rxs_q[BYTE_W-2:0], miso};
         end
      end
   end
endmodule

// File: rtl/spx_sel.sv
module spx_sel #(
   parameter int N_SLV = 4,
   parameter int SEL_W = 2
) (
   input  logic             active,
   input  logic [SEL_W-1:0] slave,
   output logic [N_SLV-1:0] cs_n
);
   for (genvar i = 0; i < N_SLV; i++) begin : g_sel
      assign cs_n[i] = !(active && (slave == SEL_W'(i)));
   end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
   parameter int N_SLV  = 4,
   parameter int DIV_W  = 8,
   parameter int LEN_W  = 4,
   parameter int BYTE_W = 8,
   localparam int SEL_W = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [SEL_W-1:0]  cmd_slave,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic              cmd_cpol,
   input  logic              cmd_cpha,
   input  logic              cmd_dc,
   input  logic [DIV_W-1:0]  cmd_div,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic [BYTE_W-1:0] rx_data,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic [N_SLV-1:0]  cs_n,
   output logic              dc
);
   import spx_pkg::*;

   localparam int EDGE_W = $clog2(2 * BYTE_W);
   localparam logic [EDGE_W-1:0] LAST_E = EDGE_W'(2 * BYTE_W - 1);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("BYTE_W must be at least 2");
   end
   if (N_SLV < 1) begin : g_bad_slv
      $error("N_SLV must be at least 1");
   end
   if (DIV_W < 1 || LEN_W < 1) begin : g_bad_width
      $error("DIV_W and LEN_W must be at least 1");
   end

   spx_state_e        st_q;
   spx_mode_t         mode_q;
   logic [SEL_W-1:0]  slave_q;
   logic [DIV_W-1:0]  div_q;
   logic [LEN_W-1:0]  left_q;
   logic [EDGE_W-1:0] edge_q;
   logic              sck_q;

   logic [DIV_W-1:0]  cmd_half;
   logic [DIV_W-1:0]  half;
   logic              restart;
   logic              run;
   logic              tick;
   logic              active;
   logic              first_edge;
   logic              do_launch;
   logic              do_sample;
   logic              take_cmd;
   logic              take_tx;
   logic              take_rx;

   assign cmd_ready = (st_q == ST_IDLE);
   assign tx_ready  = (st_q == ST_FETCH);
   assign rx_valid  = (st_q == ST_RXOUT);
   assign sck       = sck_q;
   assign dc        = mode_q.dc;

   assign take_cmd = cmd_valid && cmd_ready;
   assign take_tx  = tx_valid && tx_ready;
   assign take_rx  = rx_valid && rx_ready;

   assign cmd_half = (cmd_div == '0) ? DIV_W'(1) : cmd_div;
   assign half     = (st_q == ST_IDLE) ? cmd_half : div_q;
   assign restart  = take_cmd || take_tx || (take_rx && (left_q == '0));
   assign run      = (st_q == ST_PRE) || (st_q == ST_RUN) || (st_q == ST_TAIL);
   assign active   = (st_q == ST_FETCH) || (st_q == ST_RUN) ||
                     (st_q == ST_RXOUT) || (st_q == ST_TAIL);

   // Even edge index is the leading edge of a bit.
   assign first_edge = !edge_q[0];
   assign do_sample  = tick && (st_q == ST_RUN) && (first_edge ^ mode_q.cpha);
   assign do_launch  = tick && (st_q == ST_RUN) && (first_edge == mode_q.cpha) &&
                       (edge_q != '0);

   spx_tick #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .run     (run),
      .half    (half),
      .tick    (tick)
   );

   spx_shift #(.BYTE_W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take_tx),
      .load_val (tx_data),
      .launch   (do_launch),
      .sample   (do_sample),
      .miso     (miso),
      .mosi     (mosi),
      .rx_byte  (rx_data)
   );

   spx_sel #(.N_SLV(N_SLV), .SEL_W(SEL_W)) u_sel (
      .active (active),
      .slave  (slave_q),
      .cs_n   (cs_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         mode_q  <= '0;
         slave_q <= '0;
         div_q   <= DIV_W'(1);
         left_q  <= '0;
         edge_q  <= '0;
         sck_q   <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (take_cmd) begin
                  mode_q  <= '{cpol: cmd_cpol, cpha: cmd_cpha, dc: cmd_dc};
                  slave_q <= cmd_slave;
                  div_q   <= cmd_half;
                  left_q  <= cmd_len;
                  sck_q   <= cmd_cpol;
                  st_q    <= ST_PRE;
               end
            end
            ST_PRE: begin
               if (tick) st_q <= ST_FETCH;
            end
            ST_FETCH: begin
               if (take_tx) begin
                  edge_q <= '0;
                  st_q   <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (tick) begin
                  sck_q  <= !sck_q;
                  edge_q <= edge_q + 1'b1;
                  if (edge_q == LAST_E) st_q <= ST_RXOUT;
               end
            end
            ST_RXOUT: begin
               if (take_rx) begin
                  if (left_q == '0) begin
                     st_q <= ST_TAIL;
                  end else begin
                     left_q <= left_q - 1'b1;
                     st_q   <= ST_FETCH;
                  end
               end
            end
            ST_TAIL: begin
               if (tick) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spx_checker.sv
module spx_checker #(
   parameter int N_SLV  = 4,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SLV-1:0]  cs_n,
   input logic              sck,
   input logic              dc,
   input logic              idle_pol,
   input logic              cmd_ready,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic [BYTE_W-1:0] rx_data
);
   // R1
   a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> (sck == idle_pol));

   // R3
   a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R6
   a_r6_dc_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !(&cs_n) |-> $stable(dc));

   // R5
   a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(sck)));

   // R10
   a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (&cs_n));
endmodule

bind spi_xfer_master spx_checker #(.N_SLV(N_SLV), .BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .sck       (sck),
   .dc        (dc),
   .idle_pol  (mode_q.cpol),
   .cmd_ready (cmd_ready),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .rx_data   (rx_data)
);

// File: tb/spi_xfer_master_bench.sv
module spi_xfer_master_bench;
   localparam int N = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0, cmd_ready;
   logic [1:0] cmd_slave = '0;
   logic [3:0] cmd_len = '0;
   logic       cmd_cpol = 1'b0, cmd_cpha = 1'b0, cmd_dc = 1'b0;
   logic [7:0] cmd_div = 8'd1;
   logic       tx_valid = 1'b0, tx_ready;
   logic [7:0] tx_data = '0;
   logic       rx_valid, rx_ready = 1'b0;
   logic [7:0] rx_data;
   logic       sck, mosi, miso = 1'b0, dc;
   logic [N-1:0] cs_n;

   always #5 clk = !clk;

   spi_xfer_master u_spi_xfer_master (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_slave(cmd_slave),
      .cmd_len(cmd_len), .cmd_cpol(cmd_cpol), .cmd_cpha(cmd_cpha),
      .cmd_dc(cmd_dc), .cmd_div(cmd_div),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .dc(dc)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   logic [7:0] m_tx [0:15];
   logic [7:0] s_tx [0:15];

   // model state
   int  e_slave = 0, e_len = 0, e_div = 1;
   bit  e_cpol = 0, e_cpha = 0, e_dc = 0;
   int  cyc = 0, edges = 0, last_tog = 0, cs_fall = 0, p = 0;
   int  nbits = 0, mcap_n = 0, rx_n = 0;
   logic [7:0] cap = '0;
   bit  prev_low = 0, prev_sck = 0, prev_rxv = 0, prev_rxr = 0;
   logic [7:0] prev_rxd = '0;

   // behavioural target and per-cycle comparison
   initial begin
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         cyc++;
         if (cyc > 150000) begin
            chk(0, "watchdog", "run hung", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
         if (&cs_n) begin
            if (prev_low) begin
               chk(cyc - last_tog >= e_div, "R8", "last edge to select rise", cyc - last_tog, e_div);
               chk(edges == 16 * (e_len + 1), "R4", "edge count", edges, 16 * (e_len + 1));
            end
            chk(sck == e_cpol, "R1", "idle sck level", sck, e_cpol);
         end else begin
            logic [N-1:0] exp_cs;
            exp_cs = '1;
            exp_cs[e_slave] = 1'b0;
            if (!prev_low) begin
               cs_fall = cyc;
               edges = 0;
               nbits = 0;
               p = e_cpha ? -1 : 0;
               if (p >= 0) miso = s_tx[0][7];
            end
            chk(cs_n == exp_cs, "R3", "select lines", cs_n, exp_cs);
            chk(dc == e_dc, "R6", "dc level", dc, e_dc);
            if (sck != prev_sck) begin
               int b;
               bit first;
               b = edges % 16;
               first = (b % 2 == 0);
               if (edges == 0)
                  chk(cyc - cs_fall >= e_div, "R8", "select fall to first edge", cyc - cs_fall, e_div);
               else if (b != 0)
                  chk(cyc - last_tog == e_div, "R7", "half period", cyc - last_tog, e_div);
               else
                  chk(cyc - last_tog >= e_div, "R8", "byte gap", cyc - last_tog, e_div);
               chk(!prev_rxv, "R5", "edge while rx pending", prev_rxv, 0);
               if (first ^ e_cpha) begin
                  cap = {cap[6:0], mosi};
                  nbits++;
                  if (nbits == 8) begin
                     chk(cap == m_tx[mcap_n], "R2", "mosi byte", cap, m_tx[mcap_n]);
                     mcap_n++;
                     nbits = 0;
                  end
               end else begin
                  p++;
                  miso = s_tx[p / 8][7 - (p % 8)];
               end
               edges++;
               last_tog = cyc;
            end
            if (tx_ready && !tx_valid)
               chk(sck == e_cpol, "R9", "sck while starved", sck, e_cpol);
         end
         if (prev_rxv && !prev_rxr)
            chk(rx_valid && rx_data == prev_rxd, "R5", "held rx byte", rx_data, prev_rxd);
         if (rx_valid && rx_ready) begin
            chk(rx_data == s_tx[rx_n], "R4", "rx byte", rx_data, s_tx[rx_n]);
            rx_n++;
         end
         if (cmd_valid && cmd_ready) begin
            e_slave = int'(cmd_slave);
            e_len   = int'(cmd_len);
            e_div   = (cmd_div == 0) ? 1 : int'(cmd_div);
            e_cpol  = cmd_cpol;
            e_cpha  = cmd_cpha;
            e_dc    = cmd_dc;
            rx_n    = 0;
            mcap_n  = 0;
         end
         prev_low = !(&cs_n);
         prev_sck = sck;
         prev_rxv = rx_valid;
         prev_rxr = rx_ready;
         prev_rxd = rx_data;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic run(input int slv, input int nb, input bit cpol, input bit cpha,
                      input bit dcv, input int div, input int txgap, input int rxgap);
      for (int i = 0; i < 16; i++) begin
         m_tx[i] = 8'(8'hA5 ^ (i * 37 + slv * 11));
         s_tx[i] = 8'(8'h3C + i * 29 + slv * 7);
      end
      cmd_slave = 2'(slv);
      cmd_len   = 4'(nb - 1);
      cmd_cpol  = cpol;
      cmd_cpha  = cpha;
      cmd_dc    = dcv;
      cmd_div   = 8'(div);
      cmd_valid = 1'b1;
      while (!cmd_ready) step();
      step();
      cmd_valid = 1'b0;
      chk(cmd_ready == 1'b0, "R10", "ready after accept", cmd_ready, 0);
      fork
         begin
            for (int i = 0; i < nb; i++) begin
               repeat (txgap) step();
               tx_valid = 1'b1;
               tx_data  = m_tx[i];
               while (!tx_ready) step();
               step();
               tx_valid = 1'b0;
            end
         end
         begin
            for (int i = 0; i < nb; i++) begin
               rx_ready = 1'b0;
               while (!rx_valid) step();
               repeat (rxgap) step();
               rx_ready = 1'b1;
               step();
               rx_ready = 1'b0;
            end
         end
      join
      while (!(&cs_n)) step();
      repeat (3) step();
      chk(rx_n == nb, "R4", "bytes delivered", rx_n, nb);
      chk(mcap_n == nb, "R2", "bytes seen on mosi", mcap_n, nb);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk(cs_n == '1, "R3", "reset selects", cs_n, 4'hF);
      chk(sck == 1'b0, "R1", "reset sck", sck, 0);
      chk(cmd_ready == 1'b1, "R10", "reset cmd_ready", cmd_ready, 1);
      chk(rx_valid == 1'b0, "R5", "reset rx_valid", rx_valid, 0);
      run(0, 3, 1'b0, 1'b0, 1'b0, 2, 0, 0);   // mode 0
      run(1, 2, 1'b0, 1'b1, 1'b1, 0, 2, 1);   // mode 1, divider 0 -> 1
      run(2, 1, 1'b1, 1'b0, 1'b1, 3, 0, 4);   // mode 2, single byte
      run(3, 4, 1'b1, 1'b1, 1'b0, 2, 5, 6);   // mode 3, starvation and stalls
      run(0, 2, 1'b1, 1'b1, 1'b1, 1, 0, 0);   // fastest clock, polarity change
      run(2, 3, 1'b0, 1'b0, 1'b0, 1, 3, 3);   // polarity back to low
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule